// File: doc/BRIEF.md
# CPU Address Decode Window Unit

This unit sits between the CPU and the device fabric and decides which device a physical address belongs to. It holds a bank of programmable windows. Each window has an enable, a device identity (a 4-bit target and an 8-bit attribute), a size that is a power of two times 64 KiB, and a base. The low-numbered windows can also translate, or remap, the address they claim. Software programs and reads the windows through a 32-bit word register port. The register map uses a 16-byte stride for the remappable windows, then a reserved hole, then an 8-byte stride for the windows that have no remap registers.

Every clock the unit takes a 36-bit lookup address. One clock later it reports whether a window matched, which window won, the winning window's target and attribute, and the translated address. When more than one window matches, the lowest-numbered window wins. A remappable window replaces the window-base part of the address with its remap base and keeps the offset inside the window. A window without remap registers passes the address through unchanged, and so does a miss.

Top module: `addrwin_unit`

## Requirements
- R1: After reset every window is disabled, every register offset reads 0, and every lookup misses.
- R2: A window's control word carries enable in bit 0, target in bits 7:4, attribute in bits 15:8 and the size minus one, in 64 KiB units, in bits 31:16. Bits 3:1 read back as 0.
- R3: A window's base word carries address bits 31:16 in bits 31:16 and address bits 35:32 in bits 3:0. All other bits read back as 0.
- R4: Windows 0 to 7 sit at byte offset 16*w, with control at +0, base at +4, remap-low at +8 and remap-high at +12. Windows 8 to 19 sit at 0x90 + 8*(w-8), with control at +0 and base at +4.
- R5: The offsets 0x80 to 0x8F and 0xF0 to 0xFF read 0. Writes to them change no register.
- R6: A window matches an address when it is enabled, address bits 35:32 equal its base bits 35:32, and address bits 31:16 ANDed with the inverted size field equal its base bits 31:16.
- R7: When several windows match, the lowest-numbered one wins, and its index, target and attribute are reported.
- R8: A match in windows 0 to 7 outputs {remap-high bits 3:0, (remap-low bits 31:16 AND NOT size) OR (address bits 31:16 AND size), address bits 15:0}.
- R9: A match in windows 8 to 19 outputs the lookup address unchanged.
- R10: On a miss, hit is 0, index, target and attribute are 0, and the output address equals the lookup address.
- R11: The result for an address appears on the outputs one clock after it is presented. A lookup sampled on the same edge as a register write still uses the old window settings.
- R12: Remap-low reads translated bits 31:16 in bits 31:16 with bits 15:0 as 0. Remap-high reads bits 35:32 in bits 3:0 with bits 31:4 as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset (bits 1:0 ignored) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| lookupAddr | input | 36 | Physical address to decode |
| hit | output | 1 | A window matched the previous address |
| winIdx | output | 5 | Index of the winning window |
| target | output | 4 | Target of the winning window |
| attr | output | 8 | Attribute of the winning window |
| outAddr | output | 36 | Translated address |

## Verification
The properties assume that regAddr is settled when the clock samples it and that lookupAddr is a fresh value every cycle. The pass-through and offset-keeping properties compare against the address of the previous cycle, and they start only from the second edge after reset. The bench changes inputs only on the falling edge. It drives reads, writes and lookups only after reset is released. It runs each lookup over two edges, and it places register writes so that their effect on a lookup is fixed by R11.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_CTRL,
    KIND_BASE,
    KIND_RLO,
    KIND_RHI
  } regKind_e;

  typedef struct packed {
    regKind_e kind;
    logic     wrEn;
  } regStrobe_t;

  localparam int PAGE_SHIFT = 16;

endpackage

// File: rtl/addrwin_ctrl.sv
module addrwin_ctrl
  import addrwin_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8,
  parameter int WIN_W     = 5
) (
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  output regStrobe_t        strobe,
  output logic [WIN_W-1:0]  winSel
);

  localparam int REMAP_END   = NUM_REMAP * 16;
  localparam int PLAIN_START = REMAP_END + 16;
  localparam int PLAIN_END   = PLAIN_START + (NUM_WIN - NUM_REMAP) * 8;

  logic [REG_AW-1:0] plainOff;
  regKind_e          kind;

  always_comb begin
    plainOff = regAddr - REG_AW'(PLAIN_START);
    kind     = KIND_NONE;
    winSel   = '0;
    if (int'(regAddr) < REMAP_END) begin
      winSel = WIN_W'(regAddr >> 4);
      case (regAddr[3:2])
        2'd0:    kind = KIND_CTRL;
        2'd1:    kind = KIND_BASE;
        2'd2:    kind = KIND_RLO;
        default: kind = KIND_RHI;
      endcase
    end else if (int'(regAddr) >= PLAIN_START && int'(regAddr) < PLAIN_END) begin
      winSel = WIN_W'(NUM_REMAP) + WIN_W'(plainOff >> 3);
      kind   = plainOff[2] ? KIND_BASE : KIND_CTRL;
    end
  end

  assign strobe.kind = kind;
  assign strobe.wrEn = regWe && (kind != KIND_NONE);

endmodule

// File: rtl/addrwin_dp.sv
module addrwin_dp
  import addrwin_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int ADDR_W    = 36,
  parameter int WIN_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [WIN_W-1:0]  winSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              hit,
  output logic [WIN_W-1:0]  winIdx,
  output logic [3:0]        target,
  output logic [7:0]        attr,
  output logic [ADDR_W-1:0] outAddr
);

  localparam int HI_W  = ADDR_W - 32;
  localparam int RMP_W = (NUM_REMAP > 1) ? $clog2(NUM_REMAP) : 1;

  logic              winEn     [NUM_WIN];
  logic [3:0]        winTgt    [NUM_WIN];
  logic [7:0]        winAttr   [NUM_WIN];
  logic [15:0]       winSzM1   [NUM_WIN];
  logic [15:0]       winBaseLo [NUM_WIN];
  logic [HI_W-1:0]   winBaseHi [NUM_WIN];
  logic [15:0]       rmpLo     [NUM_REMAP];
  logic [HI_W-1:0]   rmpHi     [NUM_REMAP];

  logic [NUM_WIN-1:0] hitVec;
  logic [ADDR_W-1:0]  xlat [NUM_WIN];

  // Per-window storage, match and translation
  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    logic selMe;
    assign selMe = strobe.wrEn && (winSel == WIN_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winEn[g]     <= 1'b0;
        winTgt[g]    <= '0;
        winAttr[g]   <= '0;
        winSzM1[g]   <= '0;
        winBaseLo[g] <= '0;
        winBaseHi[g] <= '0;
      end else if (selMe && strobe.kind == KIND_CTRL) begin
        winEn[g]   <= regWdata[0];
        winTgt[g]  <= regWdata[7:4];
        winAttr[g] <= regWdata[15:8];
        winSzM1[g] <= regWdata[31:16];
      end else if (selMe && strobe.kind == KIND_BASE) begin
        winBaseLo[g] <= regWdata[31:16];
        winBaseHi[g] <= regWdata[HI_W-1:0];
      end
    end

    assign hitVec[g] = winEn[g]
                    && (lookupAddr[ADDR_W-1:32] == winBaseHi[g])
                    && ((lookupAddr[31:16] & ~winSzM1[g]) == winBaseLo[g]);

    if (g < NUM_REMAP) begin : gRemap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rmpLo[g] <= '0;
          rmpHi[g] <= '0;
        end else if (selMe && strobe.kind == KIND_RLO) begin
          rmpLo[g] <= regWdata[31:16];
        end else if (selMe && strobe.kind == KIND_RHI) begin
          rmpHi[g] <= regWdata[HI_W-1:0];
        end
      end
      assign xlat[g] = {rmpHi[g],
                        (rmpLo[g] & ~winSzM1[g]) | (lookupAddr[31:16] & winSzM1[g]),
                        lookupAddr[15:0]};
    end else begin : gPlain
      assign xlat[g] = lookupAddr;
    end
  end

  // Lowest index wins: scan downward so the last assignment is the lowest
  logic              selHit;
  logic [WIN_W-1:0]  selIdx;
  logic [3:0]        selTgt;
  logic [7:0]        selAttr;
  logic [ADDR_W-1:0] selAddr;

  always_comb begin
    selHit  = 1'b0;
    selIdx  = '0;
    selTgt  = '0;
    selAttr = '0;
    selAddr = lookupAddr;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selHit  = 1'b1;
        selIdx  = WIN_W'(i);
        selTgt  = winTgt[i];
        selAttr = winAttr[i];
        selAddr = xlat[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit     <= 1'b0;
      winIdx  <= '0;
      target  <= '0;
      attr    <= '0;
      outAddr <= '0;
    end else begin
      hit     <= selHit;
      winIdx  <= selIdx;
      target  <= selTgt;
      attr    <= selAttr;
      outAddr <= selAddr;
    end
  end

  // Readback
  always_comb begin
    regRdata = '0;
    case (strobe.kind)
      KIND_CTRL: regRdata = {winSzM1[winSel], winAttr[winSel], winTgt[winSel],
                             3'b000, winEn[winSel]};
      KIND_BASE: regRdata = {winBaseLo[winSel], {(16-HI_W){1'b0}}, winBaseHi[winSel]};
      KIND_RLO:  regRdata = {rmpLo[winSel[RMP_W-1:0]], 16'h0000};
      KIND_RHI:  regRdata = {{(32-HI_W){1'b0}}, rmpHi[winSel[RMP_W-1:0]]};
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/addrwin_unit.sv
module addrwin_unit
  import addrwin_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int ADDR_W    = 36,
  parameter int REG_AW    = 8,
  localparam int WIN_W    = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              hit,
  output logic [WIN_W-1:0]  winIdx,
  output logic [3:0]        target,
  output logic [7:0]        attr,
  output logic [ADDR_W-1:0] outAddr
);

  regStrobe_t       strobe;
  logic [WIN_W-1:0] winSel;

  addrwin_ctrl #(
    .NUM_WIN  (NUM_WIN),
    .NUM_REMAP(NUM_REMAP),
    .REG_AW   (REG_AW),
    .WIN_W    (WIN_W)
  ) u_ctrl (
    .regWe  (regWe),
    .regAddr(regAddr),
    .strobe (strobe),
    .winSel (winSel)
  );

  addrwin_dp #(
    .NUM_WIN  (NUM_WIN),
    .NUM_REMAP(NUM_REMAP),
    .ADDR_W   (ADDR_W),
    .WIN_W    (WIN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .winSel    (winSel),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .lookupAddr(lookupAddr),
    .hit       (hit),
    .winIdx    (winIdx),
    .target    (target),
    .attr      (attr),
    .outAddr   (outAddr)
  );

endmodule

// File: rtl/addrwin_chk.sv
module addrwin_chk #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int ADDR_W    = 36,
  parameter int REG_AW    = 8,
  parameter int WIN_W     = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regRdata,
  input logic [ADDR_W-1:0] lookupAddr,
  input logic              hit,
  input logic [WIN_W-1:0]  winIdx,
  input logic [3:0]        target,
  input logic [7:0]        attr,
  input logic [ADDR_W-1:0] outAddr
);

  localparam int REMAP_END   = NUM_REMAP * 16;
  localparam int PLAIN_START = REMAP_END + 16;
  localparam int PLAIN_END   = PLAIN_START + (NUM_WIN - NUM_REMAP) * 8;
  localparam int HI_W        = ADDR_W - 32;

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  assert_hole_reads_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((int'(regAddr) >= REMAP_END && int'(regAddr) < PLAIN_START) || int'(regAddr) >= PLAIN_END)
    |-> regRdata == 32'h0);

  assert_ctrl_gap_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr) < REMAP_END && regAddr[3:2] == 2'd0) |-> regRdata[3:1] == 3'b000);

  assert_rhi_upper_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr) < REMAP_END && regAddr[3:2] == 2'd3) |-> regRdata[31:HI_W] == '0);

  assert_miss_passthru_R10: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !hit) |-> (outAddr == $past(lookupAddr) && winIdx == '0 && target == '0 && attr == '0));

  assert_plain_passthru_R9: assert property (@(posedge clk) disable iff (!rstN)
    (primed && hit && int'(winIdx) >= NUM_REMAP) |-> outAddr == $past(lookupAddr));

  assert_offset_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (primed && hit) |-> outAddr[15:0] == $past(lookupAddr[15:0]));

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> int'(winIdx) < NUM_WIN);

endmodule

bind addrwin_unit addrwin_chk #(
  .NUM_WIN  (NUM_WIN),
  .NUM_REMAP(NUM_REMAP),
  .ADDR_W   (ADDR_W),
  .REG_AW   (REG_AW),
  .WIN_W    (WIN_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regRdata  (regRdata),
  .lookupAddr(lookupAddr),
  .hit       (hit),
  .winIdx    (winIdx),
  .target    (target),
  .attr      (attr),
  .outAddr   (outAddr)
);

// File: tb/test_addrwin_unit.sv
module test_addrwin_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [35:0] lookupAddr = '0;
  logic        hit;
  logic [4:0]  winIdx;
  logic [3:0]  target;
  logic [7:0]  attr;
  logic [35:0] outAddr;

  int errors = 0;
  int checks = 0;

  logic [31:0] mCtrl [20];
  logic [31:0] mBase [20];
  logic [31:0] mRlo  [8];
  logic [31:0] mRhi  [8];

  always #4 clk = ~clk;

  addrwin_unit i_addrwin_unit (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .lookupAddr(lookupAddr), .hit(hit), .winIdx(winIdx),
    .target(target), .attr(attr), .outAddr(outAddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Register map per R4; masks per R2, R3, R12; hole per R5
  task automatic modelWrite(input int off, input logic [31:0] d);
    if (off < 128) begin
      int w = off >> 4;
      case ((off >> 2) & 3)
        0: mCtrl[w] = d & 32'hFFFF_FFF1;
        1: mBase[w] = d & 32'hFFFF_000F;
        2: mRlo[w]  = d & 32'hFFFF_0000;
        default: mRhi[w] = d & 32'h0000_000F;
      endcase
    end else if (off >= 144 && off < 240) begin
      int w = 8 + ((off - 144) >> 3);
      if (((off - 144) >> 2) & 1) mBase[w] = d & 32'hFFFF_000F;
      else                        mCtrl[w] = d & 32'hFFFF_FFF1;
    end
  endtask

  function automatic logic [31:0] expRead(input int off);
    if (off < 128) begin
      case ((off >> 2) & 3)
        0: return mCtrl[off >> 4];
        1: return mBase[off >> 4];
        2: return mRlo[off >> 4];
        default: return mRhi[off >> 4];
      endcase
    end else if (off >= 144 && off < 240) begin
      if (((off - 144) >> 2) & 1) return mBase[8 + ((off - 144) >> 3)];
      return mCtrl[8 + ((off - 144) >> 3)];
    end
    return 32'h0;
  endfunction

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 8'(off); regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    modelWrite(off, d);
  endtask

  task automatic rdChk(input int off, input string tag);
    @(negedge clk);
    regAddr = 8'(off);
    #1;
    chk(regRdata == expRead(off), $sformatf("%s read off=%0h", tag, off), 64'(regRdata), 64'(expRead(off)));
  endtask

  // Expected lookup result from R6..R10
  task automatic expLookup(input logic [35:0] a, output bit eh, output int ei,
                           output logic [3:0] et, output logic [7:0] ea, output logic [35:0] eo);
    eh = 0; ei = 0; et = 0; ea = 0; eo = a;
    for (int w = 0; w < 20; w++) begin
      logic [15:0] sm = mCtrl[w][31:16];
      if (!eh && mCtrl[w][0] && a[35:32] == mBase[w][3:0]
          && ((a[31:16] & ~sm) == mBase[w][31:16])) begin
        eh = 1; ei = w; et = mCtrl[w][7:4]; ea = mCtrl[w][15:8];
        if (w < 8) eo = {mRhi[w][3:0], (mRlo[w][31:16] & ~sm) | (a[31:16] & sm), a[15:0]};
        else       eo = a;
      end
    end
  endtask

  task automatic lkChk(input logic [35:0] a, input string force_tag);
    bit eh; int ei; logic [3:0] et; logic [7:0] ea; logic [35:0] eo;
    string tag;
    expLookup(a, eh, ei, et, ea, eo);
    @(negedge clk);
    lookupAddr = a;
    @(negedge clk);
    #1;
    if (force_tag != "") tag = force_tag;
    else if (!eh)        tag = "R10";
    else if (ei < 8)     tag = "R8 R6";
    else                 tag = "R9 R6";
    chk(hit == eh && int'(winIdx) == ei && target == et && attr == ea && outAddr == eo,
        $sformatf("%s lookup %0h", tag, a),
        {hit, 3'b0, winIdx, target, attr, outAddr},
        {eh, 3'b0, 5'(ei), et, ea, eo});
  endtask

  task automatic cfg(input int w, input bit en, input logic [3:0] tg, input logic [7:0] at,
                     input logic [15:0] szm1, input logic [15:0] bLo, input logic [3:0] bHi,
                     input logic [15:0] rLo, input logic [3:0] rHi);
    int co = (w < 8) ? w * 16 : 144 + (w - 8) * 8;
    wr(co, {szm1, at, tg, 3'b000, en});
    wr(co + 4, {bLo, 12'h000, bHi});
    if (w < 8) begin
      wr(co + 8, {rLo, 16'h0000});
      wr(co + 12, {28'h0, rHi});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20; i++) begin mCtrl[i] = 0; mBase[i] = 0; end
    for (int i = 0; i < 8; i++) begin mRlo[i] = 0; mRhi[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int off = 0; off < 256; off += 4) rdChk(off, "R1");
    lkChk(36'h0_0000_0000, "R1");
    lkChk(36'h5_1234_5678, "R1");

    // R2 R3 R4 R12 R5: write every offset with a pattern, then read all back
    for (int off = 0; off < 256; off += 4)
      wr(off, 32'hA5C3_0000 ^ (32'(off) * 32'h9E37_79B9));
    for (int off = 0; off < 256; off += 4) rdChk(off, "R2 R3 R4 R5 R12");

    // Clear everything, then build a lookup configuration
    for (int off = 0; off < 256; off += 4) wr(off, 32'h0);
    for (int off = 0; off < 256; off += 4) rdChk(off, "R4");

    cfg(0,  1, 4'h1, 8'h11, 16'h000F, 16'hF000, 4'h0, 16'h2000, 4'h3);
    cfg(1,  0, 4'h9, 8'h99, 16'h00FF, 16'h9000, 4'h0, 16'h1000, 4'h0);
    cfg(3,  1, 4'h2, 8'h22, 16'h00FF, 16'h1000, 4'h0, 16'h4400, 4'h0);
    cfg(5,  1, 4'h3, 8'h33, 16'h0FFF, 16'h1000, 4'h0, 16'h5000, 4'h1);
    cfg(7,  1, 4'h4, 8'h44, 16'h0000, 16'hE123, 4'h2, 16'h7777, 4'hF);
    cfg(8,  1, 4'h5, 8'h55, 16'h03FF, 16'h8000, 4'h0, 16'h0, 4'h0);
    cfg(10, 1, 4'h6, 8'h66, 16'h0FFF, 16'h8000, 4'h0, 16'h0, 4'h0);
    cfg(19, 1, 4'h7, 8'h77, 16'hFFFF, 16'h0000, 4'h5, 16'h0, 4'h0);

    // Targeted boundaries
    lkChk(36'h2_E122_FFFF, "R6 below 64KiB window");
    lkChk(36'h2_E123_0000, "R6 R8 window start");
    lkChk(36'h2_E123_FFFF, "R6 R8 window end");
    lkChk(36'h2_E124_0000, "R6 above window");
    lkChk(36'h0_9012_3456, "R6 disabled window");
    lkChk(36'h0_10FF_FFFF, "R7 overlap low wins");
    lkChk(36'h0_1100_0000, "R7 overlap upper part");
    lkChk(36'h0_83FF_FFFF, "R7 plain overlap low wins");
    lkChk(36'h0_8400_0000, "R7 plain overlap upper");
    lkChk(36'h0_F00A_BCDE, "R8 remap offset");
    lkChk(36'h5_FFFF_FFFF, "R9 full 4GiB window");

    // Near-exhaustive sweep over bits 35:32 and 31:24
    for (int h = 0; h < 8; h++)
      for (int m = 0; m < 256; m++)
        lkChk({4'(h), 8'(m), 8'(m * 37 + h * 11), 16'(m * 1031 + h * 7)}, "");

    // R11: a lookup on the same edge as a disabling write sees the old settings
    @(negedge clk);
    regWe = 1'b1; regAddr = 8'(144 + 11 * 8); regWdata = 32'h0;
    lookupAddr = 36'h5_0000_1234;
    @(negedge clk);
    regWe = 1'b0;
    #1;
    chk(hit == 1'b1 && winIdx == 5'd19, "R11 old settings used", {hit, winIdx}, {1'b1, 5'd19});
    modelWrite(144 + 11 * 8, 32'h0);
    @(negedge clk);
    #1;
    chk(hit == 1'b0 && outAddr == 36'h5_0000_1234, "R11 new settings next cycle",
        64'({hit, outAddr}), 64'({1'b0, 36'h5_0000_1234}));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule